// File: doc/BRIEF.md
# Chunk Range Aggregator and Encoder

This block builds the range-table image of one address chunk for a longest-prefix-match forwarding structure. After a start pulse that carries the chunk's base offset in range memory, it accepts an ascending stream of (interval start, next-hop index) pairs that together cover the chunk. As each pair arrives it is compared with the next hop of the last entry it kept. A pair that repeats that next hop is dropped, so the kept list alternates in next hop. Only the interval start and the next-hop index of each kept pair are stored.

The encoding cannot be chosen until the last pair has been seen, so every kept entry is held in an internal buffer until then. When the chunk closes there are three outcomes. With a single kept entry, nothing is written and the descriptor names the next hop directly. If every kept start is 256-aligned and every next hop fits in 8 bits, the buffer is written out as 16-bit narrow entries. Otherwise it is written out as 32-bit wide entries. The narrow or wide entries go out one per cycle from the base offset upward, and the 32-bit descriptor for the chunk's direct-table slot comes out with a done pulse. A stream with a bad first start, or with more kept entries than the count field can express, ends with an error pulse and no descriptor.

Top module: `range_chunk_builder`

## Requirements
- R1: While reset is held and after it is released, mem_we_o, done_o, err_ovf_o and err_proto_o are low until a chunk produces them.
- R2: An accepted pair whose next hop equals that of the most recently kept entry is dropped, including when it is the last pair; consecutive written entries always differ in next hop.
- R3: If exactly one entry is kept, no write occurs and, one cycle after the last pair is accepted, done_o pulses with desc_o = {1'b0, 12'd0, 3'b0, next_hop[15:0]} (count code 0 marks a direct next hop).
- R4: If every kept start has bits [7:0] zero and every kept next hop is below 256, entries are written narrow: mem_wide_o = 0, mem_data_o = {16'b0, start[15:8], next_hop[7:0]}, and desc_o[31] = 1.
- R5: Otherwise entries are written wide: mem_wide_o = 1, mem_data_o = {start[15:0], next_hop[15:0]}, and desc_o[31] = 0.
- R6: With two or more kept entries, entry i (in arrival order) is written to address base + i on consecutive cycles, the first write one cycle after the last pair is accepted.
- R7: A multi-entry chunk's done_o pulses for one cycle together with its final write, with desc_o[30:19] = kept count and desc_o[18:0] = base offset.
- R8: If more than 4095 entries would be kept, err_ovf_o pulses one cycle after the last pair is accepted; no write and no done_o occur for that chunk. A chunk of exactly 4095 kept entries completes normally.
- R9: A first pair whose start is nonzero makes err_proto_o pulse one cycle after it is accepted; the chunk then ends silently at its last pair, with no write, no done_o and no err_ovf_o.
- R10: in_valid_i outside a chunk's input phase and start_i while a chunk is in progress have no effect on the outputs or on the chunk being built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Opens a chunk when idle |
| base_i | input | 19 | Range-memory base offset for the chunk, sampled with start_i |
| in_valid_i | input | 1 | Pair present on in_off_i / in_nh_i |
| in_last_i | input | 1 | Marks the final pair of the chunk |
| in_off_i | input | 16 | Interval start within the chunk |
| in_nh_i | input | 16 | Next-hop index |
| mem_we_o | output | 1 | Range-memory write strobe |
| mem_addr_o | output | 19 | Range-memory entry address |
| mem_data_o | output | 32 | Entry data, narrow entries in bits [15:0] |
| mem_wide_o | output | 1 | 1 = wide 32-bit entry, 0 = narrow 16-bit entry |
| desc_o | output | 32 | Direct-table descriptor, valid with done_o |
| done_o | output | 1 | One-cycle completion pulse |
| err_ovf_o | output | 1 | One-cycle pulse: kept-entry limit exceeded |
| err_proto_o | output | 1 | One-cycle pulse: nonzero first interval start |

## Verification
Two pairs of events can land in the same cycle. A dropped pair can close the chunk, and the final range write can coincide with the done pulse. The first case is provoked by streams whose last pair repeats the previous next hop, both for multi-entry chunks and for chunks that collapse to one direct entry. It is judged by the kept count in the descriptor and by the absence of a write for the dropped pair. The second case is judged every cycle by a queue-driven reference model, which expects the write strobe, the address, the data, done_o and the descriptor all in the one cycle set by the entry count. The same model is also run with stray start and valid activity during the write-out, at the 4095-entry limit, and one entry past it.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2,
        ST_WRITE   = 2'd3
    } rcb_state_e;

endpackage

// File: rtl/rcb_entry_store.sv
module rcb_entry_store #(
    parameter int DEPTH = 4095,
    parameter int AW    = 12,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rcb_entry_pack.sv
module rcb_entry_pack #(
    parameter int OFF_W = 16,
    parameter int NH_W  = 16,
    parameter int LOW_W = 8,
    parameter int SNH_W = 8
) (
    input  logic [OFF_W+NH_W-1:0] ent,
    input  logic                  narrow,
    output logic [OFF_W+NH_W-1:0] data
);

    localparam int ENT_W   = OFF_W + NH_W;
    localparam int SHORT_W = OFF_W - LOW_W + SNH_W;

    logic [SHORT_W-1:0] short_ent;

    assign short_ent = {ent[ENT_W-1:NH_W+LOW_W], ent[SNH_W-1:0]};

    generate
        if (SHORT_W < ENT_W) begin : g_pad
            assign data = narrow ? {{(ENT_W-SHORT_W){1'b0}}, short_ent} : ent;
        end else begin : g_nopad
            assign data = narrow ? short_ent : ent;
        end
    endgenerate

endmodule

// File: rtl/rcb_desc_form.sv
module rcb_desc_form #(
    parameter int BASE_W = 19,
    parameter int CNT_W  = 12,
    parameter int NH_W   = 16
) (
    input  logic                      direct,
    input  logic                      narrow,
    input  logic [CNT_W-1:0]          count,
    input  logic [BASE_W-1:0]         base,
    input  logic [NH_W-1:0]           nh,
    output logic [BASE_W+CNT_W:0]     desc
);

    logic [BASE_W-1:0] nh_ext;

    assign nh_ext = {{(BASE_W-NH_W){1'b0}}, nh};

    always_comb begin
        if (direct) begin
            desc = {1'b0, {CNT_W{1'b0}}, nh_ext};
        end else begin
            desc = {narrow, count, base};
        end
    end

endmodule

// File: rtl/range_chunk_builder.sv
module range_chunk_builder
    import rcb_pkg::*;
#(
    parameter int KEY_W  = 32,
    parameter int IDX_W  = 16,
    parameter int NH_W   = 16,
    parameter int BASE_W = 19,
    parameter int CNT_W  = 12,
    parameter int LOW_W  = 8,
    parameter int SNH_W  = 8,
    localparam int OFF_W    = KEY_W - IDX_W,
    localparam int ENT_W    = OFF_W + NH_W,
    localparam int DESC_W   = 1 + CNT_W + BASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic              in_valid_i,
    input  logic              in_last_i,
    input  logic [OFF_W-1:0]  in_off_i,
    input  logic [NH_W-1:0]   in_nh_i,
    output logic              mem_we_o,
    output logic [BASE_W-1:0] mem_addr_o,
    output logic [ENT_W-1:0]  mem_data_o,
    output logic              mem_wide_o,
    output logic [DESC_W-1:0] desc_o,
    output logic              done_o,
    output logic              err_ovf_o,
    output logic              err_proto_o
);

    localparam int MAX_KEPT = (1 << CNT_W) - 1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_KEPT);

    typedef struct packed {
        rcb_state_e        st;
        logic [BASE_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  idx;
        logic [NH_W-1:0]   last_nh;
        logic              all_short;
        logic              bad_proto;
        logic              ovf;
        logic              we;
        logic [BASE_W-1:0] waddr;
        logic [ENT_W-1:0]  wdata;
        logic              wide;
        logic              done;
        logic [DESC_W-1:0] desc;
        logic              e_ovf;
        logic              e_proto;
    } rcb_regs_t;

    rcb_regs_t q, d;

    logic             buf_we;
    logic [ENT_W-1:0] buf_rdata;
    logic [ENT_W-1:0] packed_data;
    logic [DESC_W-1:0] desc_val;
    logic             in_fits;
    logic             first_in;
    logic             keep_in;

    rcb_entry_store #(
        .DEPTH (MAX_KEPT),
        .AW    (CNT_W),
        .DW    (ENT_W)
    ) u_store (
        .clk   (clk),
        .we    (buf_we),
        .waddr (q.cnt),
        .wdata ({in_off_i, in_nh_i}),
        .raddr (q.idx),
        .rdata (buf_rdata)
    );

    rcb_entry_pack #(
        .OFF_W (OFF_W),
        .NH_W  (NH_W),
        .LOW_W (LOW_W),
        .SNH_W (SNH_W)
    ) u_pack (
        .ent    (buf_rdata),
        .narrow (q.all_short),
        .data   (packed_data)
    );

    rcb_desc_form #(
        .BASE_W (BASE_W),
        .CNT_W  (CNT_W),
        .NH_W   (NH_W)
    ) u_desc (
        .direct (q.cnt == CNT_ONE),
        .narrow (q.all_short),
        .count  (q.cnt),
        .base   (q.base),
        .nh     (q.last_nh),
        .desc   (desc_val)
    );

    assign in_fits  = (in_off_i[LOW_W-1:0] == '0) && (in_nh_i[NH_W-1:SNH_W] == '0);
    assign first_in = (q.cnt == '0);
    assign keep_in  = first_in || (in_nh_i != q.last_nh);

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        d.done    = 1'b0;
        d.e_ovf   = 1'b0;
        d.e_proto = 1'b0;
        buf_we    = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st        = ST_COLLECT;
                    d.base      = base_i;
                    d.cnt       = '0;
                    d.idx       = '0;
                    d.last_nh   = '0;
                    d.all_short = 1'b1;
                    d.bad_proto = 1'b0;
                    d.ovf       = 1'b0;
                end
            end

            ST_COLLECT: begin
                if (in_valid_i) begin
                    if (first_in && (in_off_i != '0)) begin
                        d.bad_proto = 1'b1;
                        d.e_proto   = 1'b1;
                    end
                    if (keep_in) begin
                        if (q.cnt == CNT_MAX) begin
                            d.ovf = 1'b1;
                        end else begin
                            buf_we      = 1'b1;
                            d.cnt       = q.cnt + CNT_ONE;
                            d.last_nh   = in_nh_i;
                            d.all_short = q.all_short & in_fits;
                        end
                    end
                    if (in_last_i) begin
                        d.st = ST_DECIDE;
                    end
                end
            end

            ST_DECIDE: begin
                if (q.bad_proto) begin
                    d.st = ST_IDLE;
                end else if (q.ovf) begin
                    d.e_ovf = 1'b1;
                    d.st    = ST_IDLE;
                end else if (q.cnt == CNT_ONE) begin
                    d.done = 1'b1;
                    d.desc = desc_val;
                    d.st   = ST_IDLE;
                end else begin
                    d.we    = 1'b1;
                    d.waddr = q.base;
                    d.wdata = packed_data;
                    d.wide  = ~q.all_short;
                    d.idx   = q.idx + CNT_ONE;
                    d.st    = ST_WRITE;
                end
            end

            ST_WRITE: begin
                d.we    = 1'b1;
                d.waddr = q.base + BASE_W'(q.idx);
                d.wdata = packed_data;
                d.wide  = ~q.all_short;
                d.idx   = q.idx + CNT_ONE;
                if (q.idx == (q.cnt - CNT_ONE)) begin
                    d.done = 1'b1;
                    d.desc = desc_val;
                    d.st   = ST_IDLE;
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_we_o    = q.we;
    assign mem_addr_o  = q.waddr;
    assign mem_data_o  = q.wdata;
    assign mem_wide_o  = q.wide;
    assign desc_o      = q.desc;
    assign done_o      = q.done;
    assign err_ovf_o   = q.e_ovf;
    assign err_proto_o = q.e_proto;

endmodule

// File: rtl/rcb_checks.sv
module rcb_checks #(
    parameter int BASE_W = 19,
    parameter int CNT_W  = 12,
    parameter int ENT_W  = 32,
    parameter int NARROW_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we_o,
    input logic [BASE_W-1:0] mem_addr_o,
    input logic [ENT_W-1:0]  mem_data_o,
    input logic              mem_wide_o,
    input logic [BASE_W+CNT_W:0] desc_o,
    input logic              done_o,
    input logic              err_ovf_o,
    input logic              err_proto_o
);

    // R8: an overflowed chunk produces neither a descriptor nor a write
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf_o |-> (!done_o && !mem_we_o));

    p_ovf_quiet_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf_o |=> !mem_we_o);

    // R6: back-to-back writes step the address by one
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: a table descriptor comes out with the final write
    p_table_done_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (desc_o[BASE_W+CNT_W-1:BASE_W] != '0)) |-> mem_we_o);

    // R3: a direct descriptor never coincides with or follows a write
    p_direct_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (desc_o[BASE_W+CNT_W-1:BASE_W] == '0)) |-> (!mem_we_o && !$past(mem_we_o)));

    // R4: narrow entries leave the upper half clear
    p_narrow_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !mem_wide_o) |-> (mem_data_o[ENT_W-1:NARROW_W] == '0));

    // R9: the protocol error is a single-cycle pulse and never meets done
    p_proto_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_proto_o |=> (!err_proto_o && !done_o));

endmodule

bind range_chunk_builder rcb_checks #(
    .BASE_W   (BASE_W),
    .CNT_W    (CNT_W),
    .ENT_W    (ENT_W),
    .NARROW_W (OFF_W - LOW_W + SNH_W)
) u_rcb_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .mem_wide_o  (mem_wide_o),
    .desc_o      (desc_o),
    .done_o      (done_o),
    .err_ovf_o   (err_ovf_o),
    .err_proto_o (err_proto_o)
);

// File: tb/range_chunk_builder_tb.sv
module range_chunk_builder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [18:0] base_i = '0;
    logic        in_valid_i = 1'b0;
    logic        in_last_i = 1'b0;
    logic [15:0] in_off_i = '0;
    logic [15:0] in_nh_i = '0;
    logic        mem_we_o;
    logic [18:0] mem_addr_o;
    logic [31:0] mem_data_o;
    logic        mem_wide_o;
    logic [31:0] desc_o;
    logic        done_o;
    logic        err_ovf_o;
    logic        err_proto_o;

    always #4 clk = ~clk;

    range_chunk_builder u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .base_i (base_i),
        .in_valid_i (in_valid_i), .in_last_i (in_last_i),
        .in_off_i (in_off_i), .in_nh_i (in_nh_i),
        .mem_we_o (mem_we_o), .mem_addr_o (mem_addr_o), .mem_data_o (mem_data_o),
        .mem_wide_o (mem_wide_o), .desc_o (desc_o), .done_o (done_o),
        .err_ovf_o (err_ovf_o), .err_proto_o (err_proto_o)
    );

    typedef struct {
        logic        we;
        logic [18:0] addr;
        logic [31:0] data;
        logic        wide;
        logic        done;
        logic [31:0] desc;
        logic        eovf;
        logic        eproto;
        string       tag;
    } exp_t;

    exp_t  exp_tab [int];
    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    string idle_tag = "R1";

    function automatic exp_t idle_exp(string t);
        exp_t e;
        e.we = 0; e.addr = '0; e.data = '0; e.wide = 0; e.done = 0;
        e.desc = '0; e.eovf = 0; e.eproto = 0; e.tag = t;
        return e;
    endfunction

    task automatic check_now();
        exp_t e;
        logic bad;
        if (exp_tab.exists(cyc)) begin
            e = exp_tab[cyc];
            exp_tab.delete(cyc);
        end else begin
            e = idle_exp(idle_tag);
        end
        n_vec++;
        bad = (mem_we_o !== e.we) || (done_o !== e.done) ||
              (err_ovf_o !== e.eovf) || (err_proto_o !== e.eproto);
        if (e.we && ((mem_addr_o !== e.addr) || (mem_data_o !== e.data) || (mem_wide_o !== e.wide)))
            bad = 1;
        if (e.done && (desc_o !== e.desc))
            bad = 1;
        if (bad) begin
            n_bad++;
            $display("FAIL %s cyc %0d: actual we=%b addr=%h data=%h wide=%b done=%b desc=%h ovf=%b proto=%b expected we=%b addr=%h data=%h wide=%b done=%b desc=%h ovf=%b proto=%b",
                     e.tag, cyc, mem_we_o, mem_addr_o, mem_data_o, mem_wide_o, done_o, desc_o,
                     err_ovf_o, err_proto_o, e.we, e.addr, e.data, e.wide, e.done, e.desc,
                     e.eovf, e.eproto);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        cyc++;
        @(negedge clk);
        check_now();
    endtask

    // Drives one chunk and schedules every expected output cycle.
    // noise: stray start/valid during the output phase (R10).
    task automatic run_chunk(input int base, input int offs[$], input int nhs[$],
                             input bit gaps, input bit noise, input string tag);
        int  k_off[$];
        int  k_nh[$];
        bit  narrow = 1;
        bit  proto = 0;
        bit  ovf = 0;
        int  c_last;
        int  end_c;
        exp_t e;
        logic [31:0] dsc;

        start_i = 1; base_i = 19'(base);
        tick();
        start_i = 0;
        for (int i = 0; i < offs.size(); i++) begin
            if (gaps && (i % 3 == 1)) begin
                in_valid_i = 0;
                tick();
                tick();
            end
            in_valid_i = 1;
            in_last_i  = (i == offs.size() - 1);
            in_off_i   = 16'(offs[i]);
            in_nh_i    = 16'(nhs[i]);
            if (k_off.size() == 0 && offs[i] != 0) begin
                proto = 1;
                e = idle_exp({tag, " R9"});
                e.eproto = 1;
                exp_tab[cyc + 1] = e;
            end
            if (k_off.size() == 0 || nhs[i] != k_nh[k_nh.size() - 1]) begin
                if (k_off.size() == 4095) begin
                    ovf = 1;
                end else begin
                    k_off.push_back(offs[i]);
                    k_nh.push_back(nhs[i]);
                    if ((offs[i] % 256) != 0 || nhs[i] >= 256) narrow = 0;
                end
            end
            tick();
        end
        in_valid_i = 0;
        in_last_i  = 0;
        c_last = cyc;
        end_c  = c_last + 1;
        if (proto) begin
            end_c = c_last + 1;
        end else if (ovf) begin
            e = idle_exp({tag, " R8"});
            e.eovf = 1;
            exp_tab[c_last + 1] = e;
        end else if (k_off.size() == 1) begin
            e = idle_exp({tag, " R3"});
            e.done = 1;
            e.desc = {1'b0, 12'd0, 3'b000, 16'(k_nh[0])};
            exp_tab[c_last + 1] = e;
        end else begin
            dsc = {narrow, 12'(k_off.size()), 19'(base)};
            for (int i = 0; i < k_off.size(); i++) begin
                e = idle_exp({tag, narrow ? " R4 R6" : " R5 R6"});
                e.we   = 1;
                e.addr = 19'(base + i);
                e.wide = ~narrow;
                e.data = narrow ? {16'h0, 8'(k_off[i] >> 8), 8'(k_nh[i])}
                                : {16'(k_off[i]), 16'(k_nh[i])};
                if (i == k_off.size() - 1) begin
                    e.done = 1;
                    e.desc = dsc;
                    e.tag  = {e.tag, " R7"};
                end
                exp_tab[c_last + 1 + i] = e;
            end
            end_c = c_last + k_off.size();
        end
        while (cyc < end_c) begin
            if (noise) begin
                start_i    = 1;
                base_i     = 19'h7_1234;
                in_valid_i = 1;
                in_last_i  = 1;
                in_off_i   = 16'h00AA;
                in_nh_i    = 16'(cyc);
            end
            tick();
        end
        start_i = 0; in_valid_i = 0; in_last_i = 0;
        tick();
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int qo[$];
        int qn[$];

        // R1: outputs quiet in and after reset
        repeat (3) tick();
        rst_n = 1;
        repeat (2) tick();
        idle_tag = "R10";

        // R2 + R4: repeated next hops merged, last pair dropped in its closing cycle
        qo = '{0, 'h0300, 'h0400, 'h0405, 'h0406, 'h1000};
        qn = '{3, 4, 3, 3, 3, 3};
        run_chunk('h100, qo, qn, 0, 0, "R2");

        // R5: unaligned start forces wide entries
        qo = '{0, 'h0480, 'h2000};
        qn = '{1, 2, 1};
        run_chunk('h200, qo, qn, 0, 0, "R5");

        // R5: next hop above 255 forces wide entries
        qo = '{0, 'h0100};
        qn = '{5, 'h1FF};
        run_chunk('h300, qo, qn, 0, 0, "R5");

        // R3: single pair gives a direct descriptor
        qo = '{0};
        qn = '{'h1234};
        run_chunk('h400, qo, qn, 0, 0, "R3");

        // R2 + R3: several pairs of one next hop collapse to direct
        qo = '{0, 'h10, 'h20};
        qn = '{7, 7, 7};
        run_chunk('h500, qo, qn, 0, 0, "R2");

        // R6: idle gaps between accepted pairs
        qo = '{0, 'h100, 'h200, 'h300, 'h400};
        qn = '{1, 2, 3, 4, 5};
        run_chunk('h600, qo, qn, 1, 0, "R6");

        // R9: nonzero first start, then recovery on a clean chunk
        qo = '{'h10, 'h20};
        qn = '{1, 2};
        run_chunk('h700, qo, qn, 0, 0, "R9");
        qo = '{0, 'h8000};
        qn = '{9, 10};
        run_chunk('h710, qo, qn, 0, 0, "R9");

        // R10: valid pairs while idle have no effect
        for (int i = 0; i < 4; i++) begin
            in_valid_i = 1; in_last_i = (i == 3);
            in_off_i = 16'(i * 5 + 1); in_nh_i = 16'(i + 40);
            tick();
        end
        in_valid_i = 0; in_last_i = 0;
        tick();

        // R10: stray start/valid during write-out leaves base and data intact
        qo = '{0, 'h0100, 'h0200, 'h0300};
        qn = '{11, 12, 13, 14};
        run_chunk('h800, qo, qn, 0, 1, "R10");
        qo = '{0};
        qn = '{'h0042};
        run_chunk('h900, qo, qn, 0, 1, "R10");

        // R8: exactly 4095 kept entries complete
        qo.delete(); qn.delete();
        for (int i = 0; i < 4095; i++) begin
            qo.push_back(i * 16);
            qn.push_back(1 + (i % 2));
        end
        run_chunk('h1000, qo, qn, 0, 0, "R8");

        // R8: one more kept entry overflows
        qo.push_back(4095 * 16);
        qn.push_back(1 + (4095 % 2));
        run_chunk('h3000, qo, qn, 0, 0, "R8");

        // R7: chunk near the top of the base range
        qo = '{0, 'h0100, 'h0F00};
        qn = '{20, 21, 22};
        run_chunk('h7FF00, qo, qn, 0, 0, "R7");

        repeat (3) tick();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule